// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block is a two-stage datapath for signed fractional arithmetic. Each cycle it can take a pair of 16-bit operands, each with the sign in the top bit and the binary point just below it. It forms their product, aligns it as a 32-bit fraction, and adds it to or subtracts it from a 40-bit accumulator. The accumulator carries eight guard bits above the 32-bit fraction. A long series of terms can therefore grow past the range of a single fraction and stay exact until the result is read out.

A mode input, sampled with each operation, picks how overflow of the 40-bit accumulator is handled. In one mode the sum clamps at the largest or smallest value. In the other it wraps in two's complement, as integer arithmetic does. Alongside the wide accumulator the block gives a 16-bit result for write-back. That result is rounded to nearest and clamped to the 16-bit fractional range. A sticky flag records any clamp until the next clear. A typical use is a filter loop: start with clear, feed coefficient and sample pairs back to back, then take the narrowed result.

Top module: `frac_mac`

## Requirements
- R1: The product term is the signed product of the two operands shifted left by one bit (a 32-bit fraction), sign-extended to 40 bits. An operation presented at clock edge N is visible on `acc_out` after edge N+1.
- R2: When both operands are 0x8000: with saturate mode on, the product term is 0x7FFFFFFF and the flag is set. With it off, the term is 0x80000000 as a signed value, which is 0xFF80000000 in the accumulator.
- R3: An operation with `acc_clr` high starts from zero instead of the old sum, and it also clears the flag before that operation's own clamps are added. `acc_clr` without `in_valid` leaves the accumulator, the flag and the result all zero.
- R4: `acc_sub` high subtracts the product term instead of adding it.
- R5: Sums up to 256 full-scale terms are kept exactly in the 40-bit accumulator. An example is 256 × 0x7FFE0002 = 0x7FFE000200.
- R6: With saturate mode on, a 40-bit overflow clamps to 0x7FFFFFFFFF (positive) or 0x8000000000 (negative) and sets the flag.
- R7: With saturate mode off, the 40-bit sum wraps modulo 2^40.
- R8: `result` is bits [31:16] of the accumulator after adding 0x8000, whenever that rounded value fits in 16 bits.
- R9: When bits [39:31] of the rounded accumulator are not all equal, `result` is 0x7FFF for a non-negative accumulator and 0x8000 for a negative one, and the flag is set.
- R10: `sat_flag` stays set until an operation with `acc_clr` reaches the accumulator.
- R11: With `in_valid` and `acc_clr` both low, the accumulator, the result and the flag hold, whatever the operands, `acc_sub` and `sat_mode` are.
- R12: After reset, `acc_out`, `result` and `sat_flag` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands carry an operation this cycle |
| op_a | input | 16 | First signed fractional operand |
| op_b | input | 16 | Second signed fractional operand |
| acc_clr | input | 1 | Start a new sum and clear the flag |
| acc_sub | input | 1 | Subtract the product instead of adding |
| sat_mode | input | 1 | 1: clamp on overflow, 0: wrap |
| acc_out | output | 40 | Accumulator |
| sat_flag | output | 1 | Sticky record of any clamp |
| result | output | 16 | Rounded, clamped 16-bit fraction |

## Verification
The checks assume that the operands and control inputs are held steady around the rising edge, and that `acc_clr` is meaningful with or without `in_valid`. The stimulus changes every input only on the falling edge. It holds `in_valid` low with nonsense on the other inputs during the hold tests. It drives inputs to zero while reset is applied, so the one-cycle look-back of the product-sign property never sees unknowns. Long runs of identical full-scale terms push the accumulator to its exact 256-term limit and one term past it in both modes, and in both directions for saturation.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;

    localparam int DEF_DATA_W  = 16;
    localparam int DEF_GUARD_W = 8;

    // Control bits that travel with an operation down the pipeline.
    typedef struct packed {
        logic vld;
        logic clr;
        logic sub;
        logic sat;
    } mac_ctl_t;

endpackage

// File: rtl/frac_mac_mul.sv
module frac_mac_mul
    import frac_mac_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int PROD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mac_ctl_t          ctl_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output mac_ctl_t          ctl_o,
    output logic [PROD_W-1:0] prod_o,
    output logic              clamp_o
);

    localparam logic [DATA_W-1:0] OP_MIN   = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [PROD_W-1:0] PROD_MAX = {1'b0, {(PROD_W-1){1'b1}}};

    typedef struct packed {
        mac_ctl_t          ctl;
        logic [PROD_W-1:0] prod;
        logic              clamp;
    } mul_st_t;

    mul_st_t st_d, st_q;

    logic signed [PROD_W-1:0] raw_prod;
    logic                     both_min;

    always_comb begin
        raw_prod = $signed(a_i) * $signed(b_i);
        both_min = (a_i == OP_MIN) && (b_i == OP_MIN);
        st_d     = st_q;
        st_d.ctl = ctl_i;
        if (both_min && ctl_i.sat) begin
            st_d.prod  = PROD_MAX;
            st_d.clamp = ctl_i.vld;
        end else begin
            st_d.prod  = raw_prod <<< 1;
            st_d.clamp = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_o   = st_q.ctl;
    assign prod_o  = st_q.prod;
    assign clamp_o = st_q.clamp;

    // R1: a product of two nonzero operands (other than the corner pair) carries the xor of their signs
    a_r1_prod_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (a_i != '0 && b_i != '0 && !(a_i == OP_MIN && b_i == OP_MIN))
        |=> (prod_o[PROD_W-1] == ($past(a_i[DATA_W-1]) ^ $past(b_i[DATA_W-1]))));

endmodule

// File: rtl/frac_mac_narrow.sv
module frac_mac_narrow #(
    parameter int DATA_W = 16,
    parameter int PROD_W = 2 * DATA_W,
    parameter int ACC_W  = PROD_W + 8
) (
    input  logic [ACC_W-1:0]  acc_i,
    output logic [DATA_W-1:0] res_o,
    output logic              clamp_o
);

    localparam int               DROP_W   = PROD_W - DATA_W;
    localparam int               TOP_W    = ACC_W + 2 - PROD_W;
    localparam logic [ACC_W:0]   HALF_LSB = (ACC_W+1)'(1) << (DROP_W - 1);
    localparam logic [DATA_W-1:0] RES_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] RES_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    logic [ACC_W:0]   rnd;
    logic [TOP_W-1:0] top_bits;
    logic             fits;

    always_comb begin
        rnd      = {acc_i[ACC_W-1], acc_i} + HALF_LSB;
        top_bits = rnd[ACC_W:PROD_W-1];
        fits     = (&top_bits) || !(|top_bits);
        clamp_o  = !fits;
        if (fits)                res_o = rnd[PROD_W-1:DROP_W];
        else if (acc_i[ACC_W-1]) res_o = RES_MIN;
        else                     res_o = RES_MAX;
    end

endmodule

// File: rtl/frac_mac_acc.sv
module frac_mac_acc
    import frac_mac_pkg::*;
#(
    parameter int DATA_W  = DEF_DATA_W,
    parameter int GUARD_W = DEF_GUARD_W,
    parameter int PROD_W  = 2 * DATA_W,
    parameter int ACC_W   = PROD_W + GUARD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mac_ctl_t          ctl_i,
    input  logic [PROD_W-1:0] prod_i,
    input  logic              pclamp_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic              flag_o,
    output logic [DATA_W-1:0] res_o
);

    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [DATA_W-1:0] res;
        logic              flag;
    } acc_st_t;

    acc_st_t st_d, st_q;

    logic [ACC_W-1:0]  base;
    logic [ACC_W-1:0]  term;
    logic [ACC_W:0]    sum_w;
    logic              ovf;
    logic              aclamp;
    logic              flag_base;
    logic [DATA_W-1:0] nres;
    logic              nclamp;

    frac_mac_narrow #(
        .DATA_W (DATA_W),
        .PROD_W (PROD_W),
        .ACC_W  (ACC_W)
    ) narrow_i (
        .acc_i   (st_d.acc),
        .res_o   (nres),
        .clamp_o (nclamp)
    );

    always_comb begin
        base      = ctl_i.clr ? '0 : st_q.acc;
        flag_base = ctl_i.clr ? 1'b0 : st_q.flag;
        term      = {{GUARD_W{prod_i[PROD_W-1]}}, prod_i};
        if (ctl_i.sub) sum_w = {base[ACC_W-1], base} - {term[ACC_W-1], term};
        else           sum_w = {base[ACC_W-1], base} + {term[ACC_W-1], term};
        ovf    = sum_w[ACC_W] != sum_w[ACC_W-1];
        aclamp = 1'b0;
        st_d   = st_q;
        if (!ctl_i.vld) begin
            st_d.acc = base;
        end else if (ovf && ctl_i.sat) begin
            st_d.acc = sum_w[ACC_W] ? ACC_MIN : ACC_MAX;
            aclamp   = 1'b1;
        end else begin
            st_d.acc = sum_w[ACC_W-1:0];
        end
        st_d.res  = nres;
        st_d.flag = flag_base | aclamp | (ctl_i.vld & pclamp_i) | nclamp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o  = st_q.acc;
    assign flag_o = st_q.flag;
    assign res_o  = st_q.res;

    // R11: an idle slot leaves the accumulator untouched
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_i.vld && !ctl_i.clr) |=> $stable(acc_o));

    // R3: a clear with no operation empties accumulator and flag
    a_r3_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.clr && !ctl_i.vld) |=> (acc_o == '0 && !flag_o));

    // R10: the flag only drops on a clear
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !ctl_i.clr) |=> flag_o);

    // R6: in clamp mode, adding a non-negative term to a non-negative sum never turns negative
    a_r6_no_sign_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.vld && ctl_i.sat && !ctl_i.clr && !ctl_i.sub &&
         !prod_i[PROD_W-1] && !acc_o[ACC_W-1]) |=> !acc_o[ACC_W-1]);

endmodule

// File: rtl/frac_mac.sv
module frac_mac
    import frac_mac_pkg::*;
#(
    parameter int DATA_W  = DEF_DATA_W,
    parameter int GUARD_W = DEF_GUARD_W,
    parameter int PROD_W  = 2 * DATA_W,
    parameter int ACC_W   = PROD_W + GUARD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              acc_clr,
    input  logic              acc_sub,
    input  logic              sat_mode,
    output logic [ACC_W-1:0]  acc_out,
    output logic              sat_flag,
    output logic [DATA_W-1:0] result
);

    localparam int DROP_W = PROD_W - DATA_W;

    mac_ctl_t          ctl_in;
    mac_ctl_t          ctl_s1;
    logic [PROD_W-1:0] prod_s1;
    logic              pclamp_s1;

    always_comb begin
        ctl_in.vld = in_valid;
        ctl_in.clr = acc_clr;
        ctl_in.sub = acc_sub;
        ctl_in.sat = sat_mode;
    end

    frac_mac_mul #(
        .DATA_W (DATA_W),
        .PROD_W (PROD_W)
    ) mul_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_i   (ctl_in),
        .a_i     (op_a),
        .b_i     (op_b),
        .ctl_o   (ctl_s1),
        .prod_o  (prod_s1),
        .clamp_o (pclamp_s1)
    );

    frac_mac_acc #(
        .DATA_W  (DATA_W),
        .GUARD_W (GUARD_W),
        .PROD_W  (PROD_W),
        .ACC_W   (ACC_W)
    ) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_i    (ctl_s1),
        .prod_i   (prod_s1),
        .pclamp_i (pclamp_s1),
        .acc_o    (acc_out),
        .flag_o   (sat_flag),
        .res_o    (result)
    );

    // R8: an in-range accumulator gives its upper fraction half, possibly rounded up by one
    a_r8_round_near: assert property (@(posedge clk) disable iff (!rst_n)
        ((&acc_out[ACC_W-1:PROD_W-1] || !(|acc_out[ACC_W-1:PROD_W-1])) &&
         acc_out[PROD_W-1:DROP_W] != {1'b0, {(DATA_W-1){1'b1}}})
        |-> (result == acc_out[PROD_W-1:DROP_W] ||
             result == acc_out[PROD_W-1:DROP_W] + 1'b1));

endmodule

// File: tb/frac_mac_tb.sv
`timescale 1ns/1ps
module frac_mac_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        acc_clr = 1'b0;
    logic        acc_sub = 1'b0;
    logic        sat_mode = 1'b0;
    logic [39:0] acc_out;
    logic        sat_flag;
    logic [15:0] result;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    frac_mac dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .acc_clr(acc_clr), .acc_sub(acc_sub), .sat_mode(sat_mode),
        .acc_out(acc_out), .sat_flag(sat_flag), .result(result)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic        sub;
        logic        clr;
        logic        sat;
        logic [39:0] acc;
        logic [15:0] res;
        logic        flag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{16'h4000, 16'h4000, 1'b0, 1'b1, 1'b0, 40'h0020000000, 16'h2000, 1'b0}, // R1 R3
        '{16'h4000, 16'h2000, 1'b0, 1'b0, 1'b0, 40'h0030000000, 16'h3000, 1'b0}, // R1
        '{16'h2000, 16'h2000, 1'b1, 1'b0, 1'b0, 40'h0028000000, 16'h2800, 1'b0}, // R4
        '{16'hC000, 16'h4000, 1'b0, 1'b0, 1'b0, 40'h0008000000, 16'h0800, 1'b0}, // R1 signed
        '{16'h0001, 16'h0001, 1'b0, 1'b0, 1'b0, 40'h0008000002, 16'h0800, 1'b0}, // R8 down
        '{16'h0001, 16'h4000, 1'b0, 1'b1, 1'b0, 40'h0000008000, 16'h0001, 1'b0}, // R8 half up
        '{16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 1'b0, 40'h007FFE8002, 16'h7FFF, 1'b0}, // R8 edge
        '{16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 1'b0, 40'h00FFFC8004, 16'h7FFF, 1'b1}, // R9 pos
        '{16'h7FFF, 16'h7FFF, 1'b1, 1'b0, 1'b0, 40'h007FFE8002, 16'h7FFF, 1'b1}, // R10
        '{16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b0, 40'hFF8001FFFE, 16'h8002, 1'b0}, // R3 R4
        '{16'h7FFF, 16'h7FFF, 1'b1, 1'b0, 1'b0, 40'hFF0003FFFC, 16'h8000, 1'b1}, // R9 neg
        '{16'h8000, 16'h8000, 1'b0, 1'b1, 1'b0, 40'hFF80000000, 16'h8000, 1'b0}, // R2 wrap
        '{16'h8000, 16'h8000, 1'b0, 1'b1, 1'b1, 40'h007FFFFFFF, 16'h7FFF, 1'b1}, // R2 clamp
        '{16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 40'h0000000000, 16'h0000, 1'b0}  // R3
    };

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [15:0] a, input logic [15:0] b,
                         input logic s, input logic c, input logic m);
        in_valid = v; op_a = a; op_b = b; acc_sub = s; acc_clr = c; sat_mode = m;
    endtask

    // clear, then n identical full-scale terms, then settle
    task automatic burst(input int n, input logic s, input logic m);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            drive(1'b1, 16'h7FFF, 16'h7FFF, s, (k == 0), m);
        end
        @(negedge clk);
        drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin
        logic [39:0] held_acc;
        logic [15:0] held_res;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 acc", acc_out, 40'h0);
        chk("R12 res", {24'h0, result}, 40'h0);
        chk("R12 flag", {39'h0, sat_flag}, 40'h0);

        // pipelined vector walk: result of vector i is visible two falling edges later
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk($sformatf("vec%0d acc R1", i-2), acc_out, VECS[i-2].acc);
                chk($sformatf("vec%0d res R8/R9", i-2), {24'h0, result}, {24'h0, VECS[i-2].res});
                chk($sformatf("vec%0d flag R10", i-2), {39'h0, sat_flag}, {39'h0, VECS[i-2].flag});
            end
            if (i < NV) drive(1'b1, VECS[i].a, VECS[i].b, VECS[i].sub, VECS[i].clr, VECS[i].sat);
            else        drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        end

        // R5: guard bits keep sums beyond one fraction exact
        burst(4, 1'b0, 1'b1);
        chk("R5 four terms", acc_out, 40'h01FFF80008);
        burst(256, 1'b0, 1'b1);
        chk("R5 256 terms", acc_out, 40'h7FFE000200);

        // R6: one term further clamps
        burst(257, 1'b0, 1'b1);
        chk("R6 pos clamp", acc_out, 40'h7FFFFFFFFF);
        chk("R6 flag", {39'h0, sat_flag}, 40'h1);
        chk("R9 res pos", {24'h0, result}, 40'h7FFF);
        burst(257, 1'b1, 1'b1);
        chk("R6 neg clamp", acc_out, 40'h8000000000);
        chk("R9 res neg", {24'h0, result}, 40'h8000);

        // R7: wrap mode rolls over
        burst(257, 1'b0, 1'b0);
        chk("R7 wrap", acc_out, 40'h807DFE0202);

        // R11: idle slots with junk on other inputs change nothing
        held_acc = acc_out;
        held_res = result;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            drive(1'b0, 16'h8000, 16'h8000, 1'b1, 1'b0, 1'b1);
        end
        @(negedge clk);
        @(negedge clk);
        chk("R11 acc hold", acc_out, held_acc);
        chk("R11 res hold", {24'h0, result}, {24'h0, held_res});
        chk("R11 flag hold", {39'h0, sat_flag}, 40'h1);

        // R3: clear without an operation
        drive(1'b0, 16'h7FFF, 16'h1234, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R3 idle clear acc", acc_out, 40'h0);
        chk("R3 idle clear flag", {39'h0, sat_flag}, 40'h0);
        chk("R3 idle clear res", {24'h0, result}, 40'h0);

        // R12: reset mid-run
        drive(1'b1, 16'h4000, 16'h4000, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R12 reset acc", acc_out, 40'h0);
        chk("R12 reset res", {24'h0, result}, 40'h0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule